// File: doc/BRIEF.md
# Programmable Display Timing Engine

This block turns a set of written timing words into the sync, data-enable and pixel outputs that drive a display link. A horizontal counter runs over each line, and a second counter runs over the whole frame in pixel clocks. Every vertical position (the sync pulse, the display window, the optional active sub-window and the fetch strobe) is compared against that frame-wide pixel-clock count rather than against a line number. Because of this, software programs vertical values as line counts multiplied by the line period, and can add a sub-line skew offset.

Pixels inside the display window but outside an enabled active sub-window carry a fixed border colour. Pixels inside the active window pass the upstream pixel through, or carry an underflow colour when the upstream source has nothing valid. A one-clock strobe can mark a chosen frame position, so that memory fetch starts ahead of the active lines. Frame and line counters can be read through a small read port.

Register words (write address, content): 0 run enable in bit 0; 1 control, with bit 29 active-horizontal enable, bit 30 active-vertical enable and bit 31 fetch enable; 2 line timing, with period in [31:16] and hsync width in [15:0]; 3 frame total in pixel clocks; 4 vsync width in pixel clocks; 5 display horizontal, with end x in [31:16] and start x in [15:0]; 6 display vertical start; 7 display vertical end; 8 active horizontal, with end x in [31:16] and start x in [15:0]; 9 active vertical start; 10 active vertical end; 11 border colour; 12 underflow colour; 13 hsync skew; 14 polarity; 15 fetch position.

Top module: `disp_timing_gen`

## Requirements
- R1: With line period P and hsync width W (word 2), the logical hsync is high exactly when the horizontal count h, which runs 0..P-1 and wraps, satisfies h < W.
- R2: The frame count f runs 0..T-1 in pixel clocks, where T is word 3, and advances in step with h. The logical vsync is high exactly when S <= f < S+V, where S is the skew (word 13) and V is word 4.
- R3: The logical data enable is high exactly when the display start x <= h <= the display end x (word 5) and the display vertical start <= f <= the display vertical end (words 6 and 7), both bounds inclusive.
- R4: When control bit 29 is set, a display pixel outside the active horizontal range (word 8, inclusive) shows the border colour (word 11). Control bit 30 does the same for the active vertical range (words 9 and 10). When a bit is clear, that axis never produces border.
- R5: Inside the active window, pix_out equals pix_in while pix_valid is 1, and equals the underflow colour (word 12) while pix_valid is 0. pix_out is zero whenever the logical data enable is low.
- R6: Polarity word 14 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de at the pins.
- R7: With control bit 31 set, fetch_stb is high for exactly the one clock in each frame where f equals the fetch position (word 15). It is never high with bit 31 clear.
- R8: While enable is 0, h, f and the frame counter are held at zero and all logical outputs are low. In the cycle after enable is written to 1, h = f = 0.
- R9: The frame counter increments on each wrap of f. The line counter increments on each wrap of h and restarts at zero on a wrap of f. Read address 0 returns enable, read address 1 returns the frame count and read address 2 returns the line count. Reads at addresses 1 and 2 return 0 while the engine is disabled.
- R10: After reset all words are zero, every pin is low and all reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Read address (0 enable, 1 frame count, 2 line count) |
| rd_data | output | 32 | Read data, combinational |
| pix_valid | input | 1 | Upstream pixel present |
| pix_in | input | DATA_W | Upstream pixel |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| fetch_stb | output | 1 | Programmable fetch strobe |
| pix_out | output | DATA_W | Pixel, border, underflow or zero |

## Verification
A fixed small mode, with no skew and a full-size active window, pins down the plain edge positions of hsync, vsync and de against the porch arithmetic. A second directed mode combines a nonzero skew, a shrunken active window, inverted polarities and the fetch strobe. This separates the frame-count comparisons from line-based behaviour and shows the border fill and the strobe position. Seeded random modes vary every porch, the active size, the skew and the polarity. Random pix_valid patterns switch between pass-through and underflow colour on every cycle. Per-frame counts of de, border pixels and strobes, together with counter reads after two frames and after disabling, check the counter and enable behaviour.

// File: rtl/dtg_pkg.sv
// Shared definitions for the display timing engine: register word
// addresses, control bit positions and the decoded timing configuration.
// Assumes horizontal positions fit 16 bits and frame positions fit 32 bits.
package dtg_pkg;

    localparam int HPOS_W = 16;
    localparam int FPOS_W = 32;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    localparam int CTRL_ACT_H_BIT = 29;
    localparam int CTRL_ACT_V_BIT = 30;
    localparam int CTRL_FETCH_BIT = 31;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd1;
    localparam logic [ADDR_W-1:0] A_LINE    = 4'd2;
    localparam logic [ADDR_W-1:0] A_FTOTAL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_VSWIDTH = 4'd4;
    localparam logic [ADDR_W-1:0] A_DHORZ   = 4'd5;
    localparam logic [ADDR_W-1:0] A_DVBEG   = 4'd6;
    localparam logic [ADDR_W-1:0] A_DVFIN   = 4'd7;
    localparam logic [ADDR_W-1:0] A_AHORZ   = 4'd8;
    localparam logic [ADDR_W-1:0] A_AVBEG   = 4'd9;
    localparam logic [ADDR_W-1:0] A_AVFIN   = 4'd10;
    localparam logic [ADDR_W-1:0] A_BORDER  = 4'd11;
    localparam logic [ADDR_W-1:0] A_UNDER   = 4'd12;
    localparam logic [ADDR_W-1:0] A_SKEW    = 4'd13;
    localparam logic [ADDR_W-1:0] A_POL     = 4'd14;
    localparam logic [ADDR_W-1:0] A_FETCH   = 4'd15;

    localparam logic [ADDR_W-1:0] RD_ENABLE = 4'd0;
    localparam logic [ADDR_W-1:0] RD_FRAME  = 4'd1;
    localparam logic [ADDR_W-1:0] RD_LINE   = 4'd2;

    // Index of each sync line in the polarity word
    localparam int SYNC_HS = 0;
    localparam int SYNC_VS = 1;
    localparam int SYNC_DE = 2;
    localparam int SYNC_N  = 3;

    typedef struct packed {
        logic              run;
        logic              act_h_en;
        logic              act_v_en;
        logic              fetch_en;
        logic [HPOS_W-1:0] h_period;
        logic [HPOS_W-1:0] hs_width;
        logic [HPOS_W-1:0] dh_start;
        logic [HPOS_W-1:0] dh_end;
        logic [HPOS_W-1:0] ah_start;
        logic [HPOS_W-1:0] ah_end;
        logic [FPOS_W-1:0] f_total;
        logic [FPOS_W-1:0] vs_width;
        logic [FPOS_W-1:0] dv_start;
        logic [FPOS_W-1:0] dv_end;
        logic [FPOS_W-1:0] av_start;
        logic [FPOS_W-1:0] av_end;
        logic [FPOS_W-1:0] skew;
        logic [FPOS_W-1:0] fetch_pos;
        logic [SYNC_N-1:0] pol;
    } dtg_cfg_t;

endpackage

// File: rtl/dtg_regs.sv
// Register bank of the timing engine. Each write of a word address
// replaces that word; there is no read-back of the words themselves.
// Assumes DATA_W <= 32 for the two colour words.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output dtg_cfg_t          cfg,
    output logic [DATA_W-1:0] border_clr,
    output logic [DATA_W-1:0] under_clr
);

    // Decode one write per cycle into the configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            border_clr <= '0;
            under_clr  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENABLE:  cfg.run <= wr_data[0];
                A_CTRL: begin
                    cfg.act_h_en <= wr_data[CTRL_ACT_H_BIT];
                    cfg.act_v_en <= wr_data[CTRL_ACT_V_BIT];
                    cfg.fetch_en <= wr_data[CTRL_FETCH_BIT];
                end
                A_LINE: begin
                    cfg.h_period <= wr_data[31:16];
                    cfg.hs_width <= wr_data[15:0];
                end
                A_FTOTAL:  cfg.f_total  <= wr_data;
                A_VSWIDTH: cfg.vs_width <= wr_data;
                A_DHORZ: begin
                    cfg.dh_end   <= wr_data[31:16];
                    cfg.dh_start <= wr_data[15:0];
                end
                A_DVBEG:   cfg.dv_start <= wr_data;
                A_DVFIN:   cfg.dv_end   <= wr_data;
                A_AHORZ: begin
                    cfg.ah_end   <= wr_data[31:16];
                    cfg.ah_start <= wr_data[15:0];
                end
                A_AVBEG:   cfg.av_start <= wr_data;
                A_AVFIN:   cfg.av_end   <= wr_data;
                A_BORDER:  border_clr   <= wr_data[DATA_W-1:0];
                A_UNDER:   under_clr    <= wr_data[DATA_W-1:0];
                A_SKEW:    cfg.skew     <= wr_data;
                A_POL:     cfg.pol      <= wr_data[SYNC_N-1:0];
                A_FETCH:   cfg.fetch_pos <= wr_data;
                default: ;
            endcase
        end
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (cfg == '0 && border_clr == '0 && under_clr == '0));

endmodule

// File: rtl/dtg_counters.sv
// Position counters: a line counter h over one period, a frame-wide
// pixel-clock counter f, and the readable line and frame tallies.
// Everything is held at zero while run is low. A period below 2 makes
// the counter stay at zero.
module dtg_counters
    import dtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HPOS_W-1:0] h_period,
    input  logic [FPOS_W-1:0] f_total,
    output logic [HPOS_W-1:0] hcnt,
    output logic [FPOS_W-1:0] fcnt,
    output logic [CNT_W-1:0]  line_cnt,
    output logic [CNT_W-1:0]  frame_cnt
);

    logic h_last;
    logic f_last;

    // Detect the final position of the line and of the frame
    always_comb begin
        h_last = (h_period <= HPOS_W'(1)) || (hcnt >= h_period - HPOS_W'(1));
        f_last = (f_total <= FPOS_W'(1)) || (fcnt >= f_total - FPOS_W'(1));
    end

    // Advance the horizontal and frame pixel-clock positions
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt <= '0;
            fcnt <= '0;
        end else begin
            hcnt <= h_last ? '0 : hcnt + HPOS_W'(1);
            fcnt <= f_last ? '0 : fcnt + FPOS_W'(1);
        end
    end

    // Tally lines within the frame and frames since enable
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_cnt  <= '0;
            frame_cnt <= '0;
        end else begin
            if (f_last) begin
                line_cnt  <= '0;
                frame_cnt <= frame_cnt + CNT_W'(1);
            end else if (h_last) begin
                line_cnt  <= line_cnt + CNT_W'(1);
            end
        end
    end

    // R8
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (hcnt == '0 && fcnt == '0 && frame_cnt == '0));

    // R9
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && fcnt == '0 && $past(fcnt) != '0) |-> line_cnt == '0);

    // R9
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |->
        (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + CNT_W'(1)));

    // R1
    h_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && h_period > HPOS_W'(1) && $stable(h_period)
         && $past(hcnt) < h_period) |-> hcnt < h_period);

endmodule

// File: rtl/dtg_window.sv
// Window decode and output stage: compares the positions against the
// programmed bounds, selects the pixel source and applies the output
// polarity. Purely combinational from the counter flops; clk and rst_n
// serve only the local checks.
module dtg_window
    import dtg_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              act_h_en,
    input  logic              act_v_en,
    input  logic              fetch_en,
    input  logic [HPOS_W-1:0] hs_width,
    input  logic [HPOS_W-1:0] dh_start,
    input  logic [HPOS_W-1:0] dh_end,
    input  logic [HPOS_W-1:0] ah_start,
    input  logic [HPOS_W-1:0] ah_end,
    input  logic [FPOS_W-1:0] vs_width,
    input  logic [FPOS_W-1:0] dv_start,
    input  logic [FPOS_W-1:0] dv_end,
    input  logic [FPOS_W-1:0] av_start,
    input  logic [FPOS_W-1:0] av_end,
    input  logic [FPOS_W-1:0] skew,
    input  logic [FPOS_W-1:0] fetch_pos,
    input  logic [SYNC_N-1:0] pol,
    input  logic [DATA_W-1:0] border_clr,
    input  logic [DATA_W-1:0] under_clr,
    input  logic [HPOS_W-1:0] hcnt,
    input  logic [FPOS_W-1:0] fcnt,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_in,
    output logic [SYNC_N-1:0] sync_pin,
    output logic              fetch_stb,
    output logic [DATA_W-1:0] pix_out
);

    logic [SYNC_N-1:0] sync_raw;
    logic h_disp, v_disp, h_act, v_act, in_act;

    // Compare positions against the display and active bounds
    always_comb begin
        h_disp = (hcnt >= dh_start) && (hcnt <= dh_end);
        v_disp = (fcnt >= dv_start) && (fcnt <= dv_end);
        h_act  = !act_h_en || ((hcnt >= ah_start) && (hcnt <= ah_end));
        v_act  = !act_v_en || ((fcnt >= av_start) && (fcnt <= av_end));
        sync_raw[SYNC_HS] = run && (hcnt < hs_width);
        sync_raw[SYNC_VS] = run && (fcnt >= skew) && ((fcnt - skew) < vs_width);
        sync_raw[SYNC_DE] = run && h_disp && v_disp;
        in_act    = sync_raw[SYNC_DE] && h_act && v_act;
        fetch_stb = run && fetch_en && (fcnt == fetch_pos);
    end

    // Choose blank, border, live pixel or underflow colour
    always_comb begin
        if (!sync_raw[SYNC_DE])  pix_out = '0;
        else if (!in_act)        pix_out = border_clr;
        else if (pix_valid)      pix_out = pix_in;
        else                     pix_out = under_clr;
    end

    // Apply per-line output polarity
    for (genvar i = 0; i < SYNC_N; i++) begin : g_pol
        assign sync_pin[i] = sync_raw[i] ^ pol[i];
    end

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (sync_pin == pol && !fetch_stb && pix_out == '0));

    // R7
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> fetch_en);

    // R5
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pin[SYNC_DE] == pol[SYNC_DE]) |-> pix_out == '0);

    // R2
    vsync_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt < skew) |-> (sync_pin[SYNC_VS] == pol[SYNC_VS]));

endmodule

// File: rtl/disp_timing_gen.sv
// Top of the display timing engine: register bank, position counters
// and window decode, plus the combinational read port for the enable
// bit and the frame and line tallies. Assumes CNT_W <= 32.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_in,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              fetch_stb,
    output logic [DATA_W-1:0] pix_out
);

    dtg_cfg_t          cfg;
    logic [DATA_W-1:0] border_clr, under_clr;
    logic [HPOS_W-1:0] hcnt;
    logic [FPOS_W-1:0] fcnt;
    logic [CNT_W-1:0]  line_cnt, frame_cnt;
    logic [SYNC_N-1:0] sync_pin;

    dtg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg        (cfg),
        .border_clr (border_clr),
        .under_clr  (under_clr)
    );

    dtg_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cfg.run),
        .h_period  (cfg.h_period),
        .f_total   (cfg.f_total),
        .hcnt      (hcnt),
        .fcnt      (fcnt),
        .line_cnt  (line_cnt),
        .frame_cnt (frame_cnt)
    );

    dtg_window #(.DATA_W(DATA_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cfg.run),
        .act_h_en   (cfg.act_h_en),
        .act_v_en   (cfg.act_v_en),
        .fetch_en   (cfg.fetch_en),
        .hs_width   (cfg.hs_width),
        .dh_start   (cfg.dh_start),
        .dh_end     (cfg.dh_end),
        .ah_start   (cfg.ah_start),
        .ah_end     (cfg.ah_end),
        .vs_width   (cfg.vs_width),
        .dv_start   (cfg.dv_start),
        .dv_end     (cfg.dv_end),
        .av_start   (cfg.av_start),
        .av_end     (cfg.av_end),
        .skew       (cfg.skew),
        .fetch_pos  (cfg.fetch_pos),
        .pol        (cfg.pol),
        .border_clr (border_clr),
        .under_clr  (under_clr),
        .hcnt       (hcnt),
        .fcnt       (fcnt),
        .pix_valid  (pix_valid),
        .pix_in     (pix_in),
        .sync_pin   (sync_pin),
        .fetch_stb  (fetch_stb),
        .pix_out    (pix_out)
    );

    assign hsync = sync_pin[SYNC_HS];
    assign vsync = sync_pin[SYNC_VS];
    assign de    = sync_pin[SYNC_DE];

    // Read port: enable bit and the tallies, which read zero when stopped
    always_comb begin
        case (rd_addr)
            RD_ENABLE: rd_data = {31'd0, cfg.run};
            RD_FRAME:  rd_data = cfg.run ? 32'(frame_cnt) : 32'd0;
            RD_LINE:   rd_data = cfg.run ? 32'(line_cnt)  : 32'd0;
            default:   rd_data = 32'd0;
        endcase
    end

    // R9
    stopped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.run && rd_addr != RD_ENABLE) |-> rd_data == 32'd0);

endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_in = '0;
    logic        hsync, vsync, de, fetch_stb;
    logic [23:0] pix_out;

    always #4 clk = ~clk;

    disp_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_valid(pix_valid), .pix_in(pix_in), .hsync(hsync),
        .vsync(vsync), .de(de), .fetch_stb(fetch_stb), .pix_out(pix_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench copy of the programmed mode
    int hper, hsw, tot, vsw, dhs, dhe, dvs, dve, ahs, ahe, avs, ave;
    int skw, fst, wdt, hgt, xres, yres;
    bit aeh, aev, fen;
    logic [2:0]  pol;
    logic [23:0] bord, undr;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected logical {fetch, de, vs, hs} at t cycles after enable
    function automatic logic [3:0] exp_raw(input int t);
        int h, f;
        logic hs, vs, d, fs;
        h  = t % hper;
        f  = t % tot;
        hs = (h < hsw);
        vs = (f >= skw) && (f - skw < vsw);
        d  = (h >= dhs) && (h <= dhe) && (f >= dvs) && (f <= dve);
        fs = fen && (f == fst);
        return {fs, d, vs, hs};
    endfunction

    function automatic bit exp_border(input int t);
        int h, f;
        bit in_a;
        h = t % hper;
        f = t % tot;
        in_a = (!aeh || (h >= ahs && h <= ahe)) && (!aev || (f >= avs && f <= ave));
        return exp_raw(t)[2] && !in_a;
    endfunction

    function automatic logic [23:0] exp_pix(input int t, input logic v, input logic [23:0] p);
        if (!exp_raw(t)[2]) return 24'd0;
        if (exp_border(t))  return bord;
        return v ? p : undr;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_mode(input int hs, input int hbp, input int w, input int hfp,
                                input int vs, input int vbp, input int hg, input int vfp,
                                input int sk, input int xr, input int yr,
                                input logic [2:0] pl, input bit fe);
        int lines;
        hper = hs + hbp + w + hfp;
        lines = vs + vbp + hg + vfp;
        tot = lines * hper;
        hsw = hs; vsw = vs * hper; skw = sk;
        dvs = (vs + vbp) * hper + sk;
        dve = (lines - vfp) * hper + sk - 1;
        dhs = hbp + hs; dhe = hper - hfp - 1;
        wdt = w; hgt = hg; xres = xr; yres = yr;
        aeh = (xr < w); aev = (yr < hg);
        ahs = dhs + (w - xr) / 2; ahe = ahs + xr - 1;
        avs = dvs + ((hg - yr) / 2) * hper; ave = avs + yr * hper - 1;
        fen = fe; fst = vs * hper + 1; pol = pl;
        bord = 24'($urandom); undr = bord ^ 24'h5A5A5A;
        wr(4'd1, {fen, aev, aeh, 29'd0});
        wr(4'd2, {16'(hper), 16'(hsw)});
        wr(4'd3, 32'(tot));
        wr(4'd4, 32'(vsw));
        wr(4'd5, {16'(dhe), 16'(dhs)});
        wr(4'd6, 32'(dvs));
        wr(4'd7, 32'(dve));
        wr(4'd8, {16'(ahe), 16'(ahs)});
        wr(4'd9, 32'(avs));
        wr(4'd10, 32'(ave));
        wr(4'd11, {8'd0, bord});
        wr(4'd12, {8'd0, undr});
        wr(4'd13, 32'(skw));
        wr(4'd14, {29'd0, pol});
        wr(4'd15, 32'(fst));
    endtask

    // Enable, compare every cycle for n cycles, then check tallies and stop
    task automatic run_mode(input int n);
        int de_cnt = 0, bd_cnt = 0, fs_cnt = 0;
        logic [3:0] e;
        logic [23:0] ep;
        wr(4'd0, 32'd1);
        for (int t = 0; t < n; t++) begin
            pix_valid = ($urandom % 4) != 0;
            pix_in = 24'($urandom);
            rd_addr = 4'd0;
            #1;
            e  = exp_raw(t);
            ep = exp_pix(t, pix_valid, pix_in);
            chk(hsync == (e[0] ^ pol[0]), "R1 hsync", hsync, e[0] ^ pol[0]);
            chk(vsync == (e[1] ^ pol[1]), "R2 vsync", vsync, e[1] ^ pol[1]);
            chk(de == (e[2] ^ pol[2]), "R3/R6 de", de, e[2] ^ pol[2]);
            chk(pix_out == ep, "R5 pix_out", pix_out, ep);
            chk(fetch_stb == e[3], "R7 fetch_stb", fetch_stb, e[3]);
            if (t == 0) chk(rd_data == 32'd1, "R9 read enable", rd_data, 1);
            if (t < tot) begin
                if (de != pol[2]) de_cnt++;
                if (de != pol[2] && pix_out == bord) bd_cnt++;
                if (fetch_stb) fs_cnt++;
            end
            @(negedge clk);
        end
        chk(de_cnt == wdt * hgt, "R3 de per frame", de_cnt, wdt * hgt);
        chk(bd_cnt == wdt * hgt - xres * yres, "R4 border per frame", bd_cnt, wdt * hgt - xres * yres);
        chk(fs_cnt == int'(fen), "R7 strobes per frame", fs_cnt, int'(fen));
        rd_addr = 4'd1; #1;
        chk(rd_data == 32'(n / tot), "R9 frame count", rd_data, n / tot);
        rd_addr = 4'd2; #1;
        chk(rd_data == 32'((n % tot) / hper), "R9 line count", rd_data, (n % tot) / hper);
        wr(4'd0, 32'd0);
        #1;
        rd_addr = 4'd1; #1;
        chk(rd_data == 32'd0, "R9 frame read when stopped", rd_data, 0);
        rd_addr = 4'd2; #1;
        chk(rd_data == 32'd0, "R8 line read when stopped", rd_data, 0);
        chk({de, vsync, hsync} == pol, "R6 idle levels follow polarity", {de, vsync, hsync}, pol);
        chk(fetch_stb == 1'b0 && pix_out == 24'd0, "R8 idle outputs", {fetch_stb, pix_out}, 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        rd_addr = 4'd0; #1;
        chk({hsync, vsync, de, fetch_stb} == 4'b0, "R10 sync pins", {hsync, vsync, de, fetch_stb}, 0);
        chk(pix_out == 24'd0, "R10 pix_out", pix_out, 0);
        chk(rd_data == 32'd0, "R10 enable read", rd_data, 0);
        rd_addr = 4'd1; #1;
        chk(rd_data == 32'd0, "R10 frame read", rd_data, 0);

        // Directed: plain mode, full active window, no skew
        program_mode(2, 3, 8, 3, 1, 2, 4, 1, 0, 8, 4, 3'b000, 1'b0);
        run_mode(2 * tot + 7);
        // Directed: skew, shrunken active window, inverted syncs, fetch
        program_mode(2, 3, 10, 3, 1, 2, 6, 2, 5, 6, 4, 3'b011, 1'b1);
        run_mode(2 * tot + 7);
        // Directed: all polarities inverted, one-pixel active window
        program_mode(1, 1, 4, 1, 2, 1, 2, 1, 3, 1, 1, 3'b111, 1'b1);
        run_mode(2 * tot + 7);

        // Seeded random modes
        for (int m = 0; m < 6; m++) begin
            int hs, hbp, w, hfp, vs, vbp, hg, vfp, sk, xr, yr;
            hs = 1 + $urandom % 3;  hbp = 1 + $urandom % 4;
            w  = 4 + $urandom % 9;  hfp = 1 + $urandom % 4;
            vs = 1 + $urandom % 2;  vbp = 1 + $urandom % 3;
            hg = 2 + $urandom % 7;  vfp = 1 + $urandom % 3;
            sk = $urandom % (hs + hbp + w + hfp);
            xr = 1 + $urandom % w;  yr = 1 + $urandom % hg;
            program_mode(hs, hbp, w, hfp, vs, vbp, hg, vfp, sk, xr, yr,
                         3'($urandom), 1'($urandom));
            run_mode(2 * tot + 7);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule